// File: doc/BRIEF.md
# Configurable Edge-Triggered Interrupt Detector

This block watches eight external request pins and turns a chosen kind of level transition on each one into a pending interrupt flag. Every pin has two enable bits. One enables detection of low-to-high transitions and the other enables detection of high-to-low transitions. With both bits set, the pin responds to either direction. With both bits clear, the pin is ignored. The pins can be asynchronous to the clock, so each one passes through a two-stage synchroniser. A third stage holds the previous sampled level, and an edge is found by comparing the two.

A detected, enabled edge sets a sticky pending flag for that pin. The flag stays set until the consumer pulses the matching bit of the clear input. Software programs the two enable registers over a small register bus. The bus writes either a whole byte or one addressed bit, and it reads a whole byte. A build option leaves out pin 1 entirely.

Software should set a pin's enable pair to 00 before it hands the pin back to general port use. While the pair is 00, level changes on the pin cannot raise a request.

Top module: `eirq_edge_detector`

## Requirements
- R1: After reset both enable registers read 0x00 and every bit of `irq_pend` is 0.
- R2: A byte write (`bus_bit_mode`=0) at offset 0x00 loads the falling-edge enable register. A byte write at offset 0x20 loads the rising-edge enable register. `bus_rdata` returns the register selected by `bus_addr` and returns 0 for any other offset.
- R3: A single-bit write (`bus_bit_mode`=1) copies `bus_wdata[0]` into bit `bus_bit_idx` of the addressed register. All other bits of that register keep their values.
- R4: Pin n uses bit n of both registers. With the pair written as (falling bit, rising bit): 00 detects nothing, 01 detects rising edges only, 10 detects falling edges only, and 11 detects both.
- R5: A pin change applied before clock edge k sets the pending bit at clock edge k+2. The bit is therefore visible after k+2 and not after k+1.
- R6: A pending bit stays set until its `pend_clr` bit is high at a clock edge. That edge clears the bit.
- R7: If a clear and a new enabled edge on the same pin meet at the same clock edge, the pending bit stays set.
- R8: Rewriting a pin's enable bits does not clear a pending bit that is already set.
- R9: When the build leaves out pin 1 (`HAS_PIN1`=0), bit 1 of both registers always reads 0, writes to that bit are ignored, and `irq_pend[1]` never rises.
- R10: While a pin's enable pair is 00, level changes on that pin never set its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Register offset (0x00 falling-edge enables, 0x20 rising-edge enables) |
| bus_bit_mode | input | 1 | 1 selects a single-bit write, 0 selects a byte write |
| bus_bit_idx | input | 3 | Bit position used by single-bit writes |
| bus_wdata | input | 8 | Write data (bit 0 only is used in single-bit mode) |
| bus_rdata | output | 8 | Read data for the register selected by `bus_addr` |
| pin_in | input | 8 | External request pins, may be asynchronous |
| pend_clr | input | 8 | Per-pin clear pulse for pending bits |
| irq_pend | output | 8 | Per-pin sticky pending request |

## Verification
The assertions assume that `pend_clr` and `pin_in` may change in any cycle and that the bus index always names one of the eight pins, which its 3-bit width guarantees. They do not assume that pins and clears are independent. The stimulus drives every input on the falling clock edge. Pins change only while the bench is counting synchroniser cycles, and clear pulses last exactly one cycle, except in the test that lines a clear up with a fresh edge on purpose. That way each per-pin sweep step starts with the synchroniser idle and no pending bits set.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int EIRQ_PINS = 8;
  localparam int EIRQ_IDX_W = $clog2(EIRQ_PINS);
  typedef logic [EIRQ_PINS-1:0] pinvec_t;

  // Next register value for a byte or single-bit write, limited to implemented bits
  function automatic pinvec_t merge_write(pinvec_t old_v, pinvec_t wd, logic bit_mode,
                                          logic [EIRQ_IDX_W-1:0] idx, pinvec_t impl);
    pinvec_t nv;
    if (bit_mode) begin
      nv = old_v;
      nv[idx] = wd[0];
    end else begin
      nv = wd;
    end
    return nv & impl;
  endfunction

  // Edges that are enabled for their pin
  function automatic pinvec_t edge_hits(pinvec_t f_en, pinvec_t r_en,
                                        pinvec_t rise_ev, pinvec_t fall_ev);
    return (rise_ev & r_en) | (fall_ev & f_en);
  endfunction

  // Sticky pending update: a new hit beats a clear
  function automatic pinvec_t pend_next(pinvec_t pend, pinvec_t clr, pinvec_t hit);
    return (pend & ~clr) | hit;
  endfunction
endpackage

// File: rtl/eirq_cfg_regs.sv
module eirq_cfg_regs
  import eirq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] FALL_OFS = 6'h00,
  parameter logic [ADDR_W-1:0] RISE_OFS = 6'h20,
  parameter pinvec_t IMPL_MASK = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  bit_mode,
  input  logic [EIRQ_IDX_W-1:0] bit_idx,
  input  pinvec_t               wdata,
  output pinvec_t               rdata,
  output pinvec_t               fall_en,
  output pinvec_t               rise_en
);
  pinvec_t fall_q, rise_q;
  logic    hit_fall, hit_rise;

  assign hit_fall = (addr == FALL_OFS);
  assign hit_rise = (addr == RISE_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
      rise_q <= '0;
    end else if (wr_en) begin
      if (hit_fall) fall_q <= merge_write(fall_q, wdata, bit_mode, bit_idx, IMPL_MASK);
      if (hit_rise) rise_q <= merge_write(rise_q, wdata, bit_mode, bit_idx, IMPL_MASK);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_fall) rdata = fall_q;
    if (hit_rise) rdata = rise_q;
  end

  assign fall_en = fall_q;
  assign rise_en = rise_q;

  // R3
  bitwr_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(bit_mode) && $past(hit_rise)) |->
      (((rise_q ^ $past(rise_q)) & ~(pinvec_t'(1) << $past(bit_idx))) == '0));

  // R3
  bitwr_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(bit_mode) && $past(hit_fall)) |->
      (((fall_q ^ $past(fall_q)) & ~(pinvec_t'(1) << $past(bit_idx))) == '0));

  // R9
  impl_bits_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_q | rise_q) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/eirq_pin_sync.sv
module eirq_pin_sync
  import eirq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t pin_async,
  output pinvec_t rise_ev,
  output pinvec_t fall_ev
);
  pinvec_t s1_q, s2_q, prev_q;

  for (genvar g = 0; g < EIRQ_PINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g]   <= 1'b0;
        s2_q[g]   <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        s1_q[g]   <= pin_async[g];
        s2_q[g]   <= s1_q[g];
        prev_q[g] <= s2_q[g];
      end
    end
    assign rise_ev[g] = s2_q[g] & ~prev_q[g];
    assign fall_ev[g] = ~s2_q[g] & prev_q[g];
  end

  // R4
  rise_fall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev & fall_ev) == '0);

  // R5
  edge_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev & ~$past(s1_q)) == '0);
endmodule

// File: rtl/eirq_pend.sv
module eirq_pend
  import eirq_pkg::*;
#(
  parameter pinvec_t IMPL_MASK = '1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t fall_en,
  input  pinvec_t rise_en,
  input  pinvec_t rise_ev,
  input  pinvec_t fall_ev,
  input  pinvec_t clr,
  output pinvec_t pend
);
  pinvec_t hit, pend_q;

  assign hit = edge_hits(fall_en, rise_en, rise_ev, fall_ev) & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next(pend_q, clr, hit);
  end

  assign pend = pend_q;

  // R6
  sticky_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~$past(clr) & ~pend_q) == '0));

  // R7
  edge_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(hit)) == $past(hit)));

  // R10
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~($past(rise_en) | $past(fall_en))) == '0));
endmodule

// File: rtl/eirq_edge_detector.sv
module eirq_edge_detector
  import eirq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] FALL_OFS = 6'h00,
  parameter logic [ADDR_W-1:0] RISE_OFS = 6'h20,
  parameter bit HAS_PIN1 = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_bit_mode,
  input  logic [EIRQ_IDX_W-1:0]      bus_bit_idx,
  input  logic [EIRQ_PINS-1:0]       bus_wdata,
  output logic [EIRQ_PINS-1:0]       bus_rdata,
  input  logic [EIRQ_PINS-1:0]       pin_in,
  input  logic [EIRQ_PINS-1:0]       pend_clr,
  output logic [EIRQ_PINS-1:0]       irq_pend
);
  localparam pinvec_t IMPL_MASK = HAS_PIN1 ? '1 : ~(pinvec_t'(1) << 1);

  pinvec_t fall_en, rise_en, rise_ev, fall_ev;

  eirq_cfg_regs #(
    .ADDR_W(ADDR_W), .FALL_OFS(FALL_OFS), .RISE_OFS(RISE_OFS), .IMPL_MASK(IMPL_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .bit_mode(bus_bit_mode), .bit_idx(bus_bit_idx), .wdata(bus_wdata),
    .rdata(bus_rdata), .fall_en(fall_en), .rise_en(rise_en)
  );

  eirq_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  eirq_pend #(.IMPL_MASK(IMPL_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n), .fall_en(fall_en), .rise_en(rise_en),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .clr(pend_clr), .pend(irq_pend)
  );

  // R9
  absent_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend & ~IMPL_MASK) == '0));
endmodule

// File: tb/sim_eirq_edge_detector.sv
module sim_eirq_edge_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_bit_mode = 1'b0;
  logic [2:0] bus_bit_idx = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd0, rd1;
  logic [7:0] pin_in = '0;
  logic [7:0] pend_clr = '0;
  logic [7:0] pend0, pend1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eirq_edge_detector u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_bit_mode(bus_bit_mode), .bus_bit_idx(bus_bit_idx), .bus_wdata(bus_wdata),
    .bus_rdata(rd0), .pin_in(pin_in), .pend_clr(pend_clr), .irq_pend(pend0)
  );

  eirq_edge_detector #(.HAS_PIN1(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_bit_mode(bus_bit_mode), .bus_bit_idx(bus_bit_idx), .bus_wdata(bus_wdata),
    .bus_rdata(rd1), .pin_in(pin_in), .pend_clr(pend_clr), .irq_pend(pend1)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_bit_mode = 1'b0; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic wr_bit(logic [5:0] a, logic [2:0] i, logic v);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_bit_mode = 1'b1; bus_bit_idx = i;
    bus_wdata = {7'h55, v};
    @(negedge clk);
    bus_wr_en = 1'b0; bus_bit_mode = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d0, output logic [7:0] d1);
    @(negedge clk);
    bus_addr = a;
    #1;
    d0 = rd0; d1 = rd1;
  endtask

  task automatic clr_all();
    @(negedge clk);
    pend_clr = 8'hFF;
    @(negedge clk);
    pend_clr = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a0, a1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h00, a0, a1); check("R1 fall reg", a0, 8'h00);
    rd(6'h20, a0, a1); check("R1 rise reg", a0, 8'h00);
    check("R1 pend", pend0, 8'h00);

    // R2 byte access and decode
    wr_byte(6'h00, 8'h3C);
    wr_byte(6'h20, 8'hA5);
    rd(6'h00, a0, a1); check("R2 fall byte", a0, 8'h3C);
    rd(6'h20, a0, a1); check("R2 rise byte", a0, 8'hA5);
    rd(6'h10, a0, a1); check("R2 other offset", a0, 8'h00);

    // R3 single-bit writes
    wr_bit(6'h20, 3'd3, 1'b1);
    rd(6'h20, a0, a1); check("R3 set bit3", a0, 8'hAD);
    wr_bit(6'h20, 3'd0, 1'b0);
    rd(6'h20, a0, a1); check("R3 clear bit0", a0, 8'hAC);
    rd(6'h00, a0, a1); check("R3 other reg untouched", a0, 8'h3C);

    // R9 pin 1 absent
    wr_byte(6'h00, 8'hFF);
    rd(6'h00, a0, a1); check("R9 byte write bit1", a1, 8'hFD);
    wr_byte(6'h20, 8'h00);
    wr_bit(6'h20, 3'd1, 1'b1);
    rd(6'h20, a0, a1);
    check("R9 bit write ignored", a1, 8'h00);
    check("R3 bit write present pin", a0, 8'h02);

    // R4 / R10 / R9 sweep over every pin and every mode
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] er, ef;
        wr_byte(6'h00, m[1] ? (8'h01 << p) : 8'h00);
        wr_byte(6'h20, m[0] ? (8'h01 << p) : 8'h00);
        clr_all();
        er = m[0] ? (8'h01 << p) : 8'h00;
        ef = m[1] ? (8'h01 << p) : 8'h00;
        @(negedge clk); pin_in[p] = 1'b1;
        repeat (4) @(negedge clk);
        check(m == 0 ? "R10 rise no cfg" : "R4 rise", pend0, er);
        check("R9 rise", pend1, er & 8'hFD);
        clr_all();
        @(negedge clk); pin_in[p] = 1'b0;
        repeat (4) @(negedge clk);
        check(m == 0 ? "R10 fall no cfg" : "R4 fall", pend0, ef);
        check("R9 fall", pend1, ef & 8'hFD);
        clr_all();
      end
    end

    // R5 latency, pin 4 rising
    wr_byte(6'h00, 8'h00);
    wr_byte(6'h20, 8'h10);
    @(negedge clk); pin_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R5 not yet at k+1", pend0, 8'h00);
    @(negedge clk); check("R5 set at k+2", pend0, 8'h10);

    // R6 sticky, then clear
    repeat (5) @(negedge clk);
    check("R6 sticky", pend0, 8'h10);

    // R8 config rewrite keeps pending
    wr_byte(6'h20, 8'h00);
    check("R8 rise rewrite", pend0, 8'h10);
    wr_bit(6'h00, 3'd4, 1'b1);
    check("R8 bit rewrite", pend0, 8'h10);
    clr_all();
    check("R6 clear", pend0, 8'h00);

    // R7 clear and new edge at the same edge: pin 4 falling, falling enabled
    @(negedge clk); pin_in[4] = 1'b0;
    @(negedge clk);
    @(negedge clk); pend_clr = 8'h10;
    @(negedge clk); pend_clr = 8'h00;
    check("R7 edge wins", pend0, 8'h10);
    clr_all();
    check("R7 clear after", pend0, 8'h00);

    // R10 pin handed away with enables at 00
    wr_byte(6'h00, 8'h00);
    wr_byte(6'h20, 8'h00);
    @(negedge clk); pin_in = 8'hFF;
    repeat (5) @(negedge clk);
    @(negedge clk); pin_in = 8'h00;
    repeat (5) @(negedge clk);
    check("R10 all pins toggled", pend0, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule